// File: doc/BRIEF.md
# Stereo Audio FIFO Refill Sequencer

This block is a hardware sequencer that answers a refill request from a stereo digital audio interface. The interface has separate left and right transmit FIFOs and one receive FIFO. A single-cycle request starts one service. The sequencer tops up both transmit FIFOs in fixed-size bursts, always giving the left channel its turn before the right. It takes samples from a decoded-sample source over a valid/ready handshake. When the source has nothing to offer, it writes zero-valued silence instead.

Once both transmit FIFOs hold at least half their depth, the sequencer drains one burst from the receive FIFO on every service. This keeps the transmit and receive sides in step. The drained samples are passed to a capture output while recording is enabled and are dropped otherwise. The service ends by pulsing clear strobes for whichever overrun and underrun flags are raised, so that the request does not fire again at once. A one-cycle done pulse is given in the same cycle.

The FIFOs, the serial audio link and the decoders sit outside this block. The block only sees the FIFO fill levels, the empty flag, the read data and the two status flags.

Top module: `afr_refill_seq`

## Requirements
- R1: While reset is applied and right after it, every write strobe, read strobe, clear strobe, `src_ready`, `cap_valid` and `done` is low.
- R2: Transmit writes come in bursts of exactly 4 consecutive cycles, one channel at a time. Within each fill round, the left burst always comes before the right burst.
- R3: A round starts only while at least one transmit level is below DEPTH/2 (8 for the default depth of 16). A channel that is already at or above DEPTH/2 at the start of a round gets no burst in that round. The fill phase ends once both levels are at or above DEPTH/2.
- R4: In a write cycle, `tx_wdata` equals `src_data` when `src_valid` is high, and that sample is consumed. When `src_valid` is low it equals 0, so a source that runs dry partway through a burst is padded with zeros.
- R5: After the fill phase, each service makes exactly 4 receive reads. `rx_rd` is only raised in cycles where `rx_empty` is low, and the drain waits for as long as the receive FIFO stays empty.
- R6: `cap_valid` is high exactly in read cycles where `rec_en` is high, with `cap_data` equal to `rx_rdata`. Reads made while `rec_en` is low produce no capture.
- R7: In the final cycle of a service, `clr_ovr` equals `ovr_flag` and `clr_unr` equals `unr_flag`. In every other cycle both are low.
- R8: `done` is a one-cycle pulse given in the final cycle of each service, once per accepted request.
- R9: A service request that arrives while a service is in progress is ignored and starts no further service.
- R10: `src_ready` is high exactly in transmit write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_req | input | 1 | Single-cycle refill request |
| rec_en | input | 1 | Recording enabled: forward received samples |
| src_valid | input | 1 | Decoded sample available |
| src_data | input | DATA_W | Decoded sample |
| src_ready | output | 1 | Sample taken this cycle if valid |
| tx_l_level | input | LVL_W | Left transmit FIFO fill level |
| tx_r_level | input | LVL_W | Right transmit FIFO fill level |
| tx_l_wr | output | 1 | Left transmit FIFO write strobe |
| tx_r_wr | output | 1 | Right transmit FIFO write strobe |
| tx_wdata | output | DATA_W | Transmit write data |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_rdata | input | DATA_W | Receive FIFO head (show-ahead) |
| rx_rd | output | 1 | Receive FIFO read strobe |
| cap_valid | output | 1 | Captured sample valid |
| cap_data | output | DATA_W | Captured sample |
| ovr_flag | input | 1 | Overrun status flag |
| unr_flag | input | 1 | Underrun status flag |
| clr_ovr | output | 1 | Overrun clear strobe |
| clr_unr | output | 1 | Underrun clear strobe |
| done | output | 1 | Service complete pulse |

## Verification
The hardest situation to reach is a single service in which several things coincide. The source runs out in the middle of a right-channel burst. One channel is already past half-full, so it must skip its burst in a later round. The receive FIFO goes empty partway through the drain. The stimulus gets there by loading the source queue with a sample count that is not a multiple of four, and by presetting unequal transmit levels. It also hands the receive FIFO fewer than four entries and refills it only after a few starved cycles. A cycle-by-cycle reference model follows each of these paths and compares every strobe and data bus on every clock.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WR_L,
    ST_WR_R,
    ST_DRAIN,
    ST_FINISH
  } afr_state_e;

  // a channel counts as filled once its level reaches half the depth
  function automatic logic at_half(input int unsigned level, input int unsigned depth);
    return level >= (depth / 2);
  endfunction

  // true on the final beat of a burst
  function automatic logic burst_end(input int unsigned beat, input int unsigned burst);
    return beat == (burst - 1);
  endfunction

endpackage

// File: rtl/afr_tx_burst.sv
module afr_tx_burst
  import afr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_l_act,
  input  logic              wr_r_act,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              tx_l_wr,
  output logic              tx_r_wr,
  output logic [DATA_W-1:0] tx_wdata,
  output logic              burst_last
);
  localparam int CNT_W = (BURST > 1) ? $clog2(BURST) : 1;

  logic [CNT_W-1:0] beat_q;
  logic             active;
  logic             take;

  assign active     = wr_l_act | wr_r_act;
  assign take       = active & src_valid;
  assign burst_last = active && burst_end(32'(beat_q), BURST);

  always_ff @(posedge clk) begin
    if (!rst_n)                    beat_q <= '0;
    else if (!active || burst_last) beat_q <= '0;
    else                            beat_q <= beat_q + 1'b1;
  end

  assign src_ready = active;
  assign tx_l_wr   = wr_l_act;
  assign tx_r_wr   = wr_r_act;
  assign tx_wdata  = take ? src_data : '0;

  assert_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_l_wr && tx_r_wr));

  assert_silence_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_l_wr || tx_r_wr) && !src_valid) |-> (tx_wdata == '0));

endmodule

// File: rtl/afr_rx_drain.sv
module afr_rx_drain
  import afr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drain_act,
  input  logic              rx_empty,
  input  logic [DATA_W-1:0] rx_rdata,
  input  logic              rec_en,
  output logic              rx_rd,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data,
  output logic              drain_last
);
  localparam int CNT_W = (BURST > 1) ? $clog2(BURST) : 1;

  logic [CNT_W-1:0] reads_q;

  assign rx_rd      = drain_act & ~rx_empty;
  assign drain_last = rx_rd && burst_end(32'(reads_q), BURST);

  always_ff @(posedge clk) begin
    if (!rst_n)          reads_q <= '0;
    else if (drain_last) reads_q <= '0;
    else if (rx_rd)      reads_q <= reads_q + 1'b1;
  end

  assign cap_valid = rx_rd & rec_en;
  assign cap_data  = cap_valid ? rx_rdata : '0;

  assert_read_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |-> !rx_empty);

  assert_capture_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (rec_en && !rx_empty));

endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_req,
  input  logic [LVL_W-1:0] tx_l_level,
  input  logic [LVL_W-1:0] tx_r_level,
  input  logic             burst_last,
  input  logic             drain_last,
  input  logic             ovr_flag,
  input  logic             unr_flag,
  output logic             wr_l_act,
  output logic             wr_r_act,
  output logic             drain_act,
  output logic             clr_ovr,
  output logic             clr_unr,
  output logic             done
);
  afr_state_e st_q, st_d;
  logic       skip_r_q, skip_r_d;
  logic       half_l, half_r;
  logic       svc_accept;
  logic       svc_ignored;

  assign half_l      = at_half(32'(tx_l_level), DEPTH);
  assign half_r      = at_half(32'(tx_r_level), DEPTH);
  assign svc_accept  = (st_q == ST_IDLE) && svc_req;
  assign svc_ignored = (st_q != ST_IDLE) && svc_req;

  always_comb begin
    st_d     = st_q;
    skip_r_d = skip_r_q;
    unique case (st_q)
      ST_IDLE:   if (svc_accept) st_d = ST_DECIDE;
      ST_DECIDE: begin
        skip_r_d = half_r;
        if (half_l && half_r) st_d = ST_DRAIN;
        else if (!half_l)     st_d = ST_WR_L;
        else                  st_d = ST_WR_R;
      end
      ST_WR_L:   if (burst_last) st_d = skip_r_q ? ST_DECIDE : ST_WR_R;
      ST_WR_R:   if (burst_last) st_d = ST_DECIDE;
      ST_DRAIN:  if (drain_last) st_d = ST_FINISH;
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      skip_r_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      skip_r_q <= skip_r_d;
    end
  end

  assign wr_l_act  = (st_q == ST_WR_L);
  assign wr_r_act  = (st_q == ST_WR_R);
  assign drain_act = (st_q == ST_DRAIN);
  assign done      = (st_q == ST_FINISH);
  assign clr_ovr   = done & ovr_flag;
  assign clr_unr   = done & unr_flag;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ignored && !done) |=> (st_q != ST_IDLE));

  assert_clear_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr || clr_unr) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/afr_refill_seq.sv
module afr_refill_seq #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int BURST  = 4,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_req,
  input  logic              rec_en,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic [LVL_W-1:0]  tx_l_level,
  input  logic [LVL_W-1:0]  tx_r_level,
  output logic              tx_l_wr,
  output logic              tx_r_wr,
  output logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_empty,
  input  logic [DATA_W-1:0] rx_rdata,
  output logic              rx_rd,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data,
  input  logic              ovr_flag,
  input  logic              unr_flag,
  output logic              clr_ovr,
  output logic              clr_unr,
  output logic              done
);
  logic wr_l_act, wr_r_act, drain_act;
  logic burst_last, drain_last;

  initial begin
    if (BURST < 2 || DEPTH < 2 * BURST)
      $error("afr_refill_seq: need BURST >= 2 and DEPTH >= 2*BURST");
  end

  afr_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .svc_req    (svc_req),
    .tx_l_level (tx_l_level),
    .tx_r_level (tx_r_level),
    .burst_last (burst_last),
    .drain_last (drain_last),
    .ovr_flag   (ovr_flag),
    .unr_flag   (unr_flag),
    .wr_l_act   (wr_l_act),
    .wr_r_act   (wr_r_act),
    .drain_act  (drain_act),
    .clr_ovr    (clr_ovr),
    .clr_unr    (clr_unr),
    .done       (done)
  );

  afr_tx_burst #(.DATA_W(DATA_W), .BURST(BURST)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_l_act   (wr_l_act),
    .wr_r_act   (wr_r_act),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .src_ready  (src_ready),
    .tx_l_wr    (tx_l_wr),
    .tx_r_wr    (tx_r_wr),
    .tx_wdata   (tx_wdata),
    .burst_last (burst_last)
  );

  afr_rx_drain #(.DATA_W(DATA_W), .BURST(BURST)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .drain_act  (drain_act),
    .rx_empty   (rx_empty),
    .rx_rdata   (rx_rdata),
    .rec_en     (rec_en),
    .rx_rd      (rx_rd),
    .cap_valid  (cap_valid),
    .cap_data   (cap_data),
    .drain_last (drain_last)
  );

  assert_no_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_l_wr |-> (32'(tx_l_level) < DEPTH)) and (tx_r_wr |-> (32'(tx_r_level) < DEPTH)));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_rd && (tx_l_wr || tx_r_wr)));

endmodule

// File: tb/test_afr_refill_seq.sv
`timescale 1ns/1ps
module test_afr_refill_seq;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int LW = 5;
  localparam int HALF = DEPTH / 2;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_req = 1'b0, rec_en = 1'b0, src_valid = 1'b0;
  logic [DW-1:0] src_data = '0, rx_rdata = '0;
  logic [LW-1:0] tx_l_level = '0, tx_r_level = '0;
  logic rx_empty = 1'b1, ovr_flag = 1'b0, unr_flag = 1'b0;
  logic src_ready, tx_l_wr, tx_r_wr, rx_rd, cap_valid, clr_ovr, clr_unr, done;
  logic [DW-1:0] tx_wdata, cap_data;

  always #10 clk = ~clk;  // 50 MHz

  afr_refill_seq i_afr_refill_seq (
    .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .rec_en(rec_en),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .tx_l_level(tx_l_level), .tx_r_level(tx_r_level),
    .tx_l_wr(tx_l_wr), .tx_r_wr(tx_r_wr), .tx_wdata(tx_wdata),
    .rx_empty(rx_empty), .rx_rdata(rx_rdata), .rx_rd(rx_rd),
    .cap_valid(cap_valid), .cap_data(cap_data),
    .ovr_flag(ovr_flag), .unr_flag(unr_flag),
    .clr_ovr(clr_ovr), .clr_unr(clr_unr), .done(done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  // environment
  logic [DW-1:0] src_q[$];
  logic [DW-1:0] rx_q[$];
  int lvl_l = 0, lvl_r = 0;
  bit gap_mode = 0;
  int rx_refill = 0, starve = 0;
  // reference model
  int m = 0, wcnt = 0, rcnt = 0;
  bit msr = 0;
  // per-service tallies
  int n_lw = 0, n_rw = 0, n_rd = 0, n_cap = 0, n_done = 0, n_zero = 0;
  bit seen_done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic clear_tally();
    n_lw = 0; n_rw = 0; n_rd = 0; n_cap = 0; n_done = 0; n_zero = 0; seen_done = 0;
  endtask

  // one clock: drive inputs, compare against the model, advance model and environment
  task automatic step();
    bit e_l, e_r, e_rd, e_cap, e_done, sl, sr;
    logic [DW-1:0] e_wd;
    src_valid  = (src_q.size() > 0) && !(gap_mode && (cyc % 5 == 2));
    src_data   = (src_q.size() > 0) ? src_q[0] : '0;
    rx_empty   = (rx_q.size() == 0);
    rx_rdata   = rx_empty ? '0 : rx_q[0];
    tx_l_level = LW'(lvl_l);
    tx_r_level = LW'(lvl_r);
    #1;
    e_l    = (m == 2);
    e_r    = (m == 3);
    e_wd   = ((e_l || e_r) && src_valid) ? src_data : '0;
    e_rd   = (m == 4) && !rx_empty;
    e_cap  = e_rd && rec_en;
    e_done = (m == 5);
    chk(tx_l_wr == e_l, "R2", "tx_l_wr", tx_l_wr, e_l);
    chk(tx_r_wr == e_r, "R2", "tx_r_wr", tx_r_wr, e_r);
    chk(src_ready == (e_l || e_r), "R10", "src_ready", src_ready, e_l || e_r);
    if (e_l || e_r) chk(tx_wdata == e_wd, "R4", "tx_wdata", tx_wdata, e_wd);
    chk(rx_rd == e_rd, "R5", "rx_rd", rx_rd, e_rd);
    chk(cap_valid == e_cap, "R6", "cap_valid", cap_valid, e_cap);
    if (e_cap) chk(cap_data == rx_rdata, "R6", "cap_data", cap_data, rx_rdata);
    chk(clr_ovr == (e_done && ovr_flag), "R7", "clr_ovr", clr_ovr, e_done && ovr_flag);
    chk(clr_unr == (e_done && unr_flag), "R7", "clr_unr", clr_unr, e_done && unr_flag);
    chk(done == e_done, "R8", "done", done, e_done);
    // model advance
    case (m)
      0: if (svc_req) m = 1;
      1: begin
        sl = (lvl_l >= HALF); sr = (lvl_r >= HALF); msr = sr; wcnt = 0; rcnt = 0;
        m = (sl && sr) ? 4 : (!sl ? 2 : 3);
      end
      2: begin wcnt++; if (wcnt == BURST) begin wcnt = 0; m = msr ? 1 : 3; end end
      3: begin wcnt++; if (wcnt == BURST) begin wcnt = 0; m = 1; end end
      4: begin if (e_rd) rcnt++; if (rcnt == BURST) m = 5; end
      default: m = 0;
    endcase
    // environment follows the design's actual strobes
    if (tx_l_wr) begin lvl_l++; n_lw++; if (tx_wdata == 0) n_zero++; end
    if (tx_r_wr) begin lvl_r++; n_rw++; if (tx_wdata == 0) n_zero++; end
    if (src_ready && src_valid && src_q.size() > 0) void'(src_q.pop_front());
    if (rx_rd && rx_q.size() > 0) begin void'(rx_q.pop_front()); n_rd++; end
    if (cap_valid) n_cap++;
    if (done) begin n_done++; seen_done = 1; end
    if (rx_q.size() == 0 && rx_refill > 0) begin
      starve++;
      if (starve >= 3) begin
        for (int i = 0; i < rx_refill; i++) rx_q.push_back(DW'(16'h7000 + i));
        rx_refill = 0; starve = 0;
      end
    end
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 20000);
      summary();
    end
    @(negedge clk);
  endtask

  task automatic run_service(input int ignore_at);
    int k;
    clear_tally();
    svc_req = 1'b1; step(); svc_req = 1'b0;
    k = 0;
    while (!seen_done && k < 400) begin
      if (k == ignore_at) begin svc_req = 1'b1; step(); svc_req = 1'b0; end
      else step();
      k++;
    end
    for (int j = 0; j < 3; j++) step();  // idle after: nothing restarts
  endtask

  task automatic post_checks(input string name, input int exp_caps);
    chk(lvl_l >= HALF && lvl_r >= HALF, "R3", {name, " both half"}, lvl_l * 100 + lvl_r, HALF * 101);
    chk(n_rd == BURST, "R5", {name, " reads"}, n_rd, BURST);
    chk(n_cap == exp_caps, "R6", {name, " captures"}, n_cap, exp_caps);
    chk(n_done == 1, "R8", {name, " done count"}, n_done, 1);
    chk(n_lw % BURST == 0 && n_rw % BURST == 0, "R2", {name, " burst multiple"}, n_lw * 100 + n_rw, 0);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!(tx_l_wr || tx_r_wr || rx_rd || src_ready || cap_valid || clr_ovr || clr_unr || done),
          "R1", "outputs in reset", {tx_l_wr, tx_r_wr, rx_rd, done}, 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    step(); step();

    // S1: empty FIFOs, plenty of data with gaps, recording on
    for (int i = 0; i < 20; i++) src_q.push_back(DW'(16'h1100 + i));
    for (int i = 0; i < 6; i++) rx_q.push_back(DW'(16'h2200 + i));
    gap_mode = 1; rec_en = 1; lvl_l = 0; lvl_r = 0;
    run_service(-1);
    post_checks("S1", 4);
    chk(n_lw == 8 && n_rw == 8, "R2", "S1 write counts", n_lw * 100 + n_rw, 808);

    // S2: no source data, unequal levels, starved receive FIFO, recording off
    src_q.delete(); rx_q.delete();
    rx_q.push_back(16'h3301); rx_q.push_back(16'h3302); rx_refill = 4;
    gap_mode = 0; rec_en = 0; lvl_l = 6; lvl_r = 2; unr_flag = 1;
    run_service(-1);
    post_checks("S2", 0);
    chk(n_lw == 4 && n_rw == 8, "R3", "S2 skip left", n_lw * 100 + n_rw, 408);
    chk(n_zero == 12, "R4", "S2 silence", n_zero, 12);

    // S3: source runs dry mid-burst, second request while busy
    src_q.delete(); rx_q.delete();
    for (int i = 0; i < 6; i++) src_q.push_back(DW'(16'h4400 + i + 1));
    for (int i = 0; i < 4; i++) rx_q.push_back(DW'(16'h5500 + i));
    rec_en = 1; lvl_l = 4; lvl_r = 0; ovr_flag = 1; unr_flag = 0;
    run_service(3);
    post_checks("S3", 4);
    chk(n_zero == 6, "R4", "S3 padding", n_zero, 6);
    chk(n_done == 1, "R9", "S3 busy request ignored", n_done, 1);

    // S4: both already half-full, drain only, both flags set
    rx_q.delete();
    for (int i = 0; i < 5; i++) rx_q.push_back(DW'(16'h6600 + i));
    lvl_l = 9; lvl_r = 12; ovr_flag = 1; unr_flag = 1; rec_en = 0;
    run_service(-1);
    post_checks("S4", 0);
    chk(n_lw == 0 && n_rw == 0, "R3", "S4 no writes", n_lw * 100 + n_rw, 0);

    summary();
  end
endmodule